// File: doc/BRIEF.md
# Timestamp seconds extension unit

Frame descriptors written by a network controller's DMA keep only a few low bits of the seconds count next to the nanoseconds of the capture. This unit rebuilds the full 48-bit seconds value. It takes the two 32-bit descriptor timestamp words and the seconds of the live time-of-day timer, and splits the words into nanoseconds and truncated seconds. The upper seconds bits come from the live timer. If the truncated field has wrapped since capture, the upper part is first reduced by one.

Wrap detection looks at a single bit. When the top bit of the truncated field is set and the same bit of the live seconds is clear, the field has rolled over between capture and now. The result is therefore exact only when the frame is handled less than half the truncated range of seconds (32 s at the default width) after it was stamped. The result appears in a register one clock after an accepted input, together with a one-cycle valid strobe. An input is accepted only when its descriptor timestamp-valid flag is set.

Top module: `ts_sec_extend`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0 and `out_sec` and `out_ns` are all zeros.
- R2: When `in_valid` and `in_ts_ok` are both 1 at a clock edge, `out_valid` is 1 for exactly the following cycle.
- R3: When `in_valid` or `in_ts_ok` is 0 at an edge, the next cycle has `out_valid` 0 and `out_sec`/`out_ns` keep their previous values.
- R4: `out_ns` equals bits [29:0] of `in_word_a` of the accepted input.
- R5: The 6 low bits of `out_sec` equal the truncated seconds, which are {`in_word_b`[3:0], `in_word_a`[31:30]} (word B bits above the word A bits).
- R6: When the truncated seconds bit 5 is 0, or `live_sec` bit 5 is 1, `out_sec`[47:6] equals `live_sec`[47:6].
- R7: When the truncated seconds bit 5 is 1 and `live_sec` bit 5 is 0, `out_sec`[47:6] equals `live_sec`[47:6] minus 1, modulo 2^42.
- R8: Bits [31:4] of `in_word_b` and bits [4:0] of `live_sec` have no effect on the outputs.
- R9: For a capture time C and live time C + d with 0 <= d < 32, `out_sec` equals C modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Descriptor words presented this cycle |
| in_ts_ok | input | 1 | Timestamp-valid flag of the descriptor |
| in_word_a | input | 32 | First timestamp word: nanoseconds [29:0], seconds low bits [31:30] |
| in_word_b | input | 32 | Second timestamp word: seconds high bits [3:0] |
| live_sec | input | 48 | Seconds of the running timer |
| out_valid | output | 1 | One-cycle strobe, result valid |
| out_sec | output | 48 | Rebuilt seconds |
| out_ns | output | 30 | Nanoseconds |

## Verification
The properties assume that `live_sec` at the accept edge is the timer value that applies to the frame. They also rely on the wrap decision being taken from bit 5 of both the truncated field and the live seconds. None of them assumes that frame age is bounded, so they hold for any word and timer values. The stimulus mixes fully random words and timer values, which exercise both the wrap and no-wrap paths, with cases built from a random capture time and a live time that is 0 to 31 seconds later. Only the second kind is used to check exact recovery of the capture time, because that is the only range in which recovery is defined.

// File: rtl/ts_sec_extend_pkg.sv
// Package: shared widths of the descriptor timestamp layout.
// Assumes 32-bit descriptor words and a 48-bit seconds counter.
package ts_sec_extend_pkg;
    localparam int DESC_W = 32;
    localparam int SEC_FULL_W = 48;
    typedef logic [DESC_W-1:0] desc_word_t;
endpackage

// File: rtl/ts_field_unpack.sv
// Splits the two descriptor timestamp words into nanoseconds and the
// truncated seconds field. Assumes TRUNC_W is wider than the number of
// seconds bits held above the nanoseconds in word A.
module ts_field_unpack
    import ts_sec_extend_pkg::*;
#(
    parameter int NS_W    = 30,
    parameter int TRUNC_W = 6
) (
    input  desc_word_t         word_a,
    input  desc_word_t         word_b,
    output logic [NS_W-1:0]    ns,
    output logic [TRUNC_W-1:0] trunc_sec
);
    localparam int LO_W = DESC_W - NS_W;
    localparam int HI_W = TRUNC_W - LO_W;

    logic unused_word_b;

    // Nanoseconds sit in the low part of word A.
    always_comb ns = word_a[NS_W-1:0];

    // Truncated seconds: word B low bits above word A top bits.
    always_comb trunc_sec = {word_b[HI_W-1:0], word_a[DESC_W-1:NS_W]};

    // Upper bits of word B carry nothing for this unit.
    always_comb unused_word_b = &{1'b0, word_b[DESC_W-1:HI_W]};
endmodule

// File: rtl/ts_sec_merge.sv
// Joins the truncated seconds with the upper bits of the live timer and
// steps the upper part back by one when the truncated field has wrapped.
// Assumes the frame is younger than 2^(TRUNC_W-1) seconds.
module ts_sec_merge #(
    parameter int SEC_W   = 48,
    parameter int TRUNC_W = 6
) (
    input  logic [TRUNC_W-1:0] trunc_sec,
    input  logic [SEC_W-1:0]   live_sec,
    output logic [SEC_W-1:0]   full_sec,
    output logic               wrapped
);
    localparam int UP_W = SEC_W - TRUNC_W;

    logic [UP_W-1:0] upper;
    logic            unused_live;

    // Wrap: captured top bit set while the live timer's is already clear.
    always_comb wrapped = trunc_sec[TRUNC_W-1] & ~live_sec[TRUNC_W-1];

    // Upper seconds from the live timer, one less after a wrap.
    always_comb upper = live_sec[SEC_W-1:TRUNC_W] - UP_W'(wrapped);

    // Final seconds value.
    always_comb full_sec = {upper, trunc_sec};

    // Live bits below the top truncated bit are not needed.
    always_comb unused_live = &{1'b0, live_sec[TRUNC_W-2:0]};
endmodule

// File: rtl/ts_sec_extend.sv
// Top: accepts a descriptor timestamp when its valid flag is set and
// registers the rebuilt seconds and nanoseconds one cycle later with a
// single-cycle strobe. Outputs hold between results.
module ts_sec_extend
    import ts_sec_extend_pkg::*;
#(
    parameter int NS_W    = 30,
    parameter int TRUNC_W = 6,
    parameter int SEC_W   = SEC_FULL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ts_ok,
    input  logic [31:0]       in_word_a,
    input  logic [31:0]       in_word_b,
    input  logic [SEC_W-1:0]  live_sec,
    output logic              out_valid,
    output logic [SEC_W-1:0]  out_sec,
    output logic [NS_W-1:0]   out_ns
);
    logic [NS_W-1:0]    ns_c;
    logic [TRUNC_W-1:0] trunc_c;
    logic [SEC_W-1:0]   sec_c;
    logic               wrap_c;
    logic               accept;
    logic               unused_wrap;

    ts_field_unpack #(.NS_W(NS_W), .TRUNC_W(TRUNC_W)) u_unpack (
        .word_a    (in_word_a),
        .word_b    (in_word_b),
        .ns        (ns_c),
        .trunc_sec (trunc_c)
    );

    ts_sec_merge #(.SEC_W(SEC_W), .TRUNC_W(TRUNC_W)) u_merge (
        .trunc_sec (trunc_c),
        .live_sec  (live_sec),
        .full_sec  (sec_c),
        .wrapped   (wrap_c)
    );

    // Accept only descriptors whose timestamp is marked valid.
    always_comb accept = in_valid & in_ts_ok;

    // Wrap flag is informational inside the merge stage only.
    always_comb unused_wrap = &{1'b0, wrap_c};

    // Output register: strobe follows accept, data loads on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sec   <= '0;
            out_ns    <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_sec <= sec_c;
                out_ns  <= ns_c;
            end
        end
    end
endmodule

// File: rtl/ts_sec_extend_chk.sv
// Checker for ts_sec_extend: relates the ports of one cycle to the
// registered result of the next. Bound to every instance of the top.
module ts_sec_extend_chk #(
    parameter int NS_W    = 30,
    parameter int TRUNC_W = 6,
    parameter int SEC_W   = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ts_ok,
    input logic [31:0]       in_word_a,
    input logic [31:0]       in_word_b,
    input logic [SEC_W-1:0]  live_sec,
    input logic              out_valid,
    input logic [SEC_W-1:0]  out_sec,
    input logic [NS_W-1:0]   out_ns
);
    localparam int LO_W = 32 - NS_W;
    localparam int HI_W = TRUNC_W - LO_W;
    localparam int UP_W = SEC_W - TRUNC_W;

    logic               acc;
    logic [TRUNC_W-1:0] tr;
    logic               wr;

    always_comb acc = in_valid & in_ts_ok;
    always_comb tr  = {in_word_b[HI_W-1:0], in_word_a[31:NS_W]};
    always_comb wr  = tr[TRUNC_W-1] & ~live_sec[TRUNC_W-1];

    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);
    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !out_valid);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(out_sec) && $stable(out_ns)));
    p_ns_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_ns == $past(in_word_a[NS_W-1:0]));
    p_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_sec[TRUNC_W-1:0] == $past(tr));
    p_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !wr) |=> out_sec[SEC_W-1:TRUNC_W] == $past(live_sec[SEC_W-1:TRUNC_W]));
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr) |=> out_sec[SEC_W-1:TRUNC_W] ==
                        $past(live_sec[SEC_W-1:TRUNC_W]) - UP_W'(1));
endmodule

bind ts_sec_extend ts_sec_extend_chk #(
    .NS_W(NS_W), .TRUNC_W(TRUNC_W), .SEC_W(SEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ts_ok  (in_ts_ok),
    .in_word_a (in_word_a),
    .in_word_b (in_word_b),
    .live_sec  (live_sec),
    .out_valid (out_valid),
    .out_sec   (out_sec),
    .out_ns    (out_ns)
);

// File: tb/sim_ts_sec_extend.sv
module sim_ts_sec_extend;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ts_ok;
    logic [31:0] in_word_a;
    logic [31:0] in_word_b;
    logic [47:0] live_sec;
    logic        out_valid;
    logic [47:0] out_sec;
    logic [29:0] out_ns;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ts_sec_extend u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ts_ok(in_ts_ok),
        .in_word_a(in_word_a), .in_word_b(in_word_b), .live_sec(live_sec),
        .out_valid(out_valid), .out_sec(out_sec), .out_ns(out_ns)
    );

    // Expected seconds from the requirements (add then subtract form).
    function automatic logic [47:0] exp_sec(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [47:0] live);
        logic [5:0]  t;
        logic [47:0] r;
        t = {b[3:0], a[31:30]};
        r = {live[47:6], 6'd0} + {42'd0, t};
        if (t[5] && !live[5]) r = r - 48'd64;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one input at a falling edge, sample after the next rising edge.
    task automatic apply(input bit v, input bit ok, input logic [31:0] a,
                         input logic [31:0] b, input logic [47:0] live);
        in_valid = v; in_ts_ok = ok; in_word_a = a; in_word_b = b; live_sec = live;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic accept_and_check(input logic [31:0] a, input logic [31:0] b,
                                    input logic [47:0] live, input string req);
        logic [47:0] e;
        e = exp_sec(a, b, live);
        apply(1'b1, 1'b1, a, b, live);
        chk(out_valid == 1'b1, "R2", 64'(out_valid), 64'd1);
        chk(out_ns == a[29:0], "R4", 64'(out_ns), 64'(a[29:0]));
        chk(out_sec == e, req, 64'(out_sec), 64'(e));
    endtask

    // Build descriptor words from a capture time and check recovery.
    task automatic age_case(input logic [47:0] cap, input int age);
        logic [31:0] a, b;
        logic [29:0] ns;
        ns = 30'($urandom);
        a = {cap[1:0], ns};
        b = {$urandom, cap[5:2]} >> 0;
        b[3:0] = cap[5:2];
        apply(1'b1, 1'b1, a, b, cap + 48'(age));
        chk(out_sec == cap, "R9", 64'(out_sec), 64'(cap));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [47:0] held_s;
        logic [29:0] held_n;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        in_valid = 1'b1; in_ts_ok = 1'b1;
        in_word_a = 32'hFFFF_FFFF; in_word_b = 32'hFFFF_FFFF; live_sec = '1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
        chk(out_sec == 48'd0 && out_ns == 30'd0, "R1", 64'(out_sec), 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && out_sec == 48'd0, "R1", 64'(out_sec), 64'd0);

        // R6 no wrap, R7 wrap, including underflow of the upper part
        accept_and_check({2'b01, 30'h1234567}, 32'h0000_0002, 48'h0000_1234_5680, "R6");
        accept_and_check({2'b11, 30'h3FFFFFFF}, 32'h0000_000F, 48'h0000_0000_0040, "R7");
        accept_and_check({2'b10, 30'd0}, 32'h0000_0008, 48'h0000_0000_0000, "R7");
        accept_and_check({2'b10, 30'd5}, 32'h0000_000A, 48'hABCD_0000_00E0, "R6");
        accept_and_check({2'b00, 30'd7}, 32'h0000_0000, 48'hFFFF_FFFF_FFFF, "R6");

        // R8: ignored bits of word B and of the live low bits
        accept_and_check({2'b01, 30'd99}, 32'hFFFF_FFF3, 48'h0000_0000_1F1F, "R8");
        accept_and_check({2'b01, 30'd99}, 32'h0000_0003, 48'h0000_0000_1F00, "R8");

        // R3: rejected inputs leave the outputs unchanged
        held_s = out_sec; held_n = out_ns;
        apply(1'b1, 1'b0, 32'hDEAD_BEEF, 32'h5, 48'h1111_2222_3333);
        chk(out_valid == 1'b0, "R3", 64'(out_valid), 64'd0);
        chk(out_sec == held_s && out_ns == held_n, "R3", 64'(out_sec), 64'(held_s));
        apply(1'b0, 1'b1, 32'hCAFE_F00D, 32'h9, 48'h4444_5555_6666);
        chk(out_valid == 1'b0, "R3", 64'(out_valid), 64'd0);
        chk(out_sec == held_s && out_ns == held_n, "R3", 64'(out_sec), 64'(held_s));

        // R9 boundaries: ages 0 and 31 across the field wrap
        age_case(48'h0000_0000_003F, 31);
        age_case(48'h0000_1234_5660, 0);
        age_case(48'hFFFF_FFFF_FFFF, 31);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 1) == 0) begin
                logic [47:0] lv;
                lv = {16'($urandom), $urandom};
                if ($urandom_range(0, 3) == 0)
                    apply(1'b1, 1'b0, $urandom, $urandom, lv);
                else
                    accept_and_check($urandom, $urandom, lv, "R5");
            end else begin
                age_case({16'($urandom), $urandom}, $urandom_range(0, 31));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule